// File: doc/BRIEF.md
# Synchronous Reset Answer Generator

This block produces the fixed 32-bit answer that a synchronous memory card returns after its card-reset line is pulsed. A rising edge on the card-reset input, seen while chip select is active (low) and no nonvolatile write is busy, loads a four-byte header. The first header bit is placed on the serial data output at once, before the host issues any serial clock pulse. Each falling edge of the serial clock then moves on to the next bit until all 32 bits have been sent.

The line inputs are sampled on the system clock and are assumed synchronous to it. Edges are found by comparing each sample with the previous one. The four header bytes are parameters. They are sent first byte first, and within each byte the least significant bit goes first. Raising chip select ends the answer at once. A new card-reset edge during an answer starts the answer again from its first bit.

Top module: `rst_answer_gen`

## Requirements
- R1: A rising edge of `card_rst` while `cs_n` is 0 and `wr_busy` is 0 sets `sda_oe` to 1 one clock later. `sda_out` then carries header bit b1 with no `scl` pulse.
- R2: Bit bK is bit (K-1) of the 32-bit word {HDR3,HDR2,HDR1,HDR0}. HDR0 is sent first and each byte goes LSB first. With the defaults 19h, 55h, AAh, 55h, the word is 55AA5519h.
- R3: The output moves to the next bit one clock after a falling edge of `scl`. A rising edge of `scl` leaves `sda_out` unchanged.
- R4: The 32nd falling edge of `scl` clears `sda_oe` one clock later. After that, further `scl` pulses leave `sda_oe` at 0.
- R5: `cs_n` at 1 clears `sda_oe` one clock later. `scl` pulses after `cs_n` returns to 0 do not resume the answer.
- R6: A rising edge of `card_rst` while `wr_busy` is 1 is ignored, and `sda_oe` stays 0.
- R7: A rising edge of `card_rst` during an answer restarts it, so b1 is shown one clock later.
- R8: A rising edge of `card_rst` while `cs_n` is 1 is ignored.
- R9: After reset, and whenever `sda_oe` is 0, `sda_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_rst | input | 1 | Card reset line; its rising edge triggers the answer |
| cs_n | input | 1 | Chip select, active low |
| scl | input | 1 | Serial clock from the host |
| wr_busy | input | 1 | A nonvolatile write cycle is in progress |
| sda_out | output | 1 | Serial data bit of the answer |
| sda_oe | output | 1 | Output enable for the serial data line |

## Verification
Every result is due exactly one system clock after the input change that causes it. Load, shift, abort and release each go through one register after the edge detector. The bench drives inputs on the falling clock edge and queues the expected output for that step. A monitor then samples 2 ns after the next rising edge and compares against the queue. The expected bit index is tracked from the requirements alone: SCL falls advance it, card-reset edges reset it, and `cs_n` or the 32nd fall clears it.

// File: rtl/ans_pkg.sv
package ans_pkg;
  localparam int HDR_BYTES = 4;
  localparam int HDR_BITS  = HDR_BYTES * 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } ans_state_e;
endpackage

// File: rtl/line_edge.sv
module line_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] = line_i[g] & ~prev_q[g];
    assign fall_o[g] = ~line_i[g] & prev_q[g];
  end
endmodule

// File: rtl/answer_seq.sv
module answer_seq
  import ans_pkg::*;
#(
  parameter int          HDR_W = HDR_BITS,
  parameter logic [HDR_W-1:0] HDR_WORD = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_busy,
  input  logic trig_rise,
  input  logic clk_fall,
  output logic sda_out,
  output logic sda_oe
);
  localparam int CNT_W = $clog2(HDR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_W - 1);

  ans_state_e       state_q, state_d;
  logic [HDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sh_en;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    sh_en   = 1'b0;
    if (cs_n) begin
      state_d = ST_IDLE;
    end else if (trig_rise && !wr_busy) begin
      state_d = ST_SEND;
      sh_d    = HDR_WORD;
      cnt_d   = '0;
      sh_en   = 1'b1;
    end else if (state_q == ST_SEND && clk_fall) begin
      sh_d  = {1'b0, sh_q[HDR_W-1:1]};
      cnt_d = cnt_q + 1'b1;
      sh_en = 1'b1;
      if (cnt_q == LAST) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (sh_en) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign sda_oe  = (state_q == ST_SEND);
  assign sda_out = sda_oe & sh_q[0];

  // R1: an accepted trigger turns the driver on next cycle
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && !cs_n && !wr_busy) |=> sda_oe);

  // R3: without a falling SCL, trigger or deselect the bit holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !cs_n && !trig_rise && !clk_fall) |=> $stable(sda_out));

  // R6: a busy write keeps an idle block idle
  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sda_oe && wr_busy) |=> !sda_oe);

  // R4: the driver is released after the last bit
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && cnt_q == LAST && clk_fall && !cs_n && !trig_rise) |=> !sda_oe);
endmodule

// File: rtl/rst_answer_gen.sv
module rst_answer_gen
  import ans_pkg::*;
#(
  parameter logic [7:0] HDR0 = 8'h19,
  parameter logic [7:0] HDR1 = 8'h55,
  parameter logic [7:0] HDR2 = 8'hAA,
  parameter logic [7:0] HDR3 = 8'h55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_rst,
  input  logic cs_n,
  input  logic scl,
  input  logic wr_busy,
  output logic sda_out,
  output logic sda_oe
);
  localparam logic [HDR_BITS-1:0] WORD = {HDR3, HDR2, HDR1, HDR0};

  logic [1:0] rise, fall;

  line_edge #(.W(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({scl, card_rst}),
    .rise_o (rise),
    .fall_o (fall)
  );

  answer_seq #(.HDR_W(HDR_BITS), .HDR_WORD(WORD)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_busy   (wr_busy),
    .trig_rise (rise[0]),
    .clk_fall  (fall[1]),
    .sda_out   (sda_out),
    .sda_oe    (sda_oe)
  );

  // R5: deselect drops the driver next cycle
  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sda_oe);

  // R9: data is quiet while not driving
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe |-> !sda_out);
endmodule

// File: tb/test_rst_answer_gen.sv
module test_rst_answer_gen;
  logic clk = 1'b0;
  logic rst_n, card_rst, cs_n, scl, wr_busy;
  logic sda_out, sda_oe;

  localparam logic [31:0] HDR = 32'h55AA5519;

  always #5 clk = ~clk;

  rst_answer_gen i_rst_answer_gen (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .cs_n(cs_n),
    .scl(scl), .wr_busy(wr_busy), .sda_out(sda_out), .sda_oe(sda_oe)
  );

  typedef struct {
    logic  oe;
    logic  bit_v;
    string req;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  int idx = 0;
  bit act = 0;
  bit done = 0;

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (sda_oe !== e.oe || sda_out !== e.bit_v) begin
        n_fail++;
        $display("FAIL %s: oe/sda actual %b/%b expected %b/%b",
                 e.req, sda_oe, sda_out, e.oe, e.bit_v);
      end
    end
  end

  function automatic logic exp_bit();
    return act ? HDR[idx] : 1'b0;
  endfunction

  task automatic cyc(input logic r, input logic c, input logic s,
                     input logic b, input string req);
    exp_t e;
    @(negedge clk);
    card_rst = r; cs_n = c; scl = s; wr_busy = b;
    e.oe = act; e.bit_v = exp_bit(); e.req = req;
    q.push_back(e);
  endtask

  task automatic trigger(input string req);
    act = 1; idx = 0;
    cyc(1, 0, 0, 0, req);
    cyc(0, 0, 0, 0, req);
  endtask

  task automatic pulse(input string req);
    cyc(0, 0, 1, 0, req);
    if (act) begin
      idx++;
      if (idx == 32) begin act = 0; idx = 0; end
    end
    cyc(0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; card_rst = 0; cs_n = 1; scl = 0; wr_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");
    // R8: trigger while deselected
    cyc(1, 1, 0, 0, "R8");
    cyc(0, 1, 0, 0, "R8");
    cyc(0, 0, 0, 0, "R8");
    // R6: trigger while write busy
    cyc(1, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, "R6");
    // R1 and R2/R3/R4: full answer
    trigger("R1");
    for (int i = 0; i < 32; i++) pulse("R2");
    pulse("R4");
    pulse("R4");
    // R7: restart mid-answer
    trigger("R7");
    for (int i = 0; i < 5; i++) pulse("R3");
    trigger("R7");
    pulse("R7");
    // R5: abort by deselect
    for (int i = 0; i < 3; i++) pulse("R3");
    act = 0; idx = 0;
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, "R5");
    pulse("R5");
    pulse("R5");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule